// File: doc/BRIEF.md
# Send-Command Dispatcher for Inter-Core Interrupts and Mailboxes

This block takes 64-bit command words written to one of three send ports and turns each one into register accesses on a target core. An interrupt-post command sets one bit in the target's pending-status word. A mailbox command writes one of eight 32-bit mailbox words. An arbitrary-register command writes any 16-bit register address on the target. Both register-writing commands can protect individual bytes with a keep mask. When any mask bit is set, the dispatcher reads the old word, merges it with the new data and writes the result back. When the mask is clear, it writes the data directly without reading first.

Commands arrive on a valid/ready handshake that carries the port offset and the command word. The dispatcher works on one command at a time. It drives a simple register master: target-core select, register address, read and write strobes, and write and read data. The fabric answers combinationally with the read data and a flag that says whether the selected core exists. When a command finishes, the dispatcher raises a one-cycle done pulse. A drop flag marks commands that were discarded.

Top module: `send_dispatch`

## Requirements
- R1: While reset is held and right after it is released, `cmd_ready` is 1, `rq_rd`, `rq_wr` and `done` are 0.
- R2: The target core is taken from command bits 25:16 and driven on `rq_core`. If `core_present` is 0 for that core, the command makes no read and no write, and it ends with `done` and `dropped` both 1.
- R3: A command on port 0x040 is an interrupt post. It makes exactly one write and no read. The write goes to register 0x0008 and carries a word with only bit number cmd[4:0] set. The keep mask and the payload are ignored.
- R4: A command on port 0x048 is a mailbox send to register address 0x0020 + 4 × cmd[4:2]. The other low address bits of the command have no effect on the address.
- R5: A command on port 0x158 (the mailbox port plus 0x110) writes the register whose address is cmd[15:0].
- R6: For a mailbox or arbitrary-register command whose keep mask cmd[30:27] is zero, cmd[63:32] is written in one write with no read before it.
- R7: For a mailbox or arbitrary-register command with a nonzero keep mask, the dispatcher makes one read and then one write to the same core and address. Byte i of the written word (bits 8i+7:8i) is the old byte when cmd[27+i] is 1, and otherwise the byte from cmd[63:32].
- R8: A command on any other port offset is accepted with no bus access and ends with `done` and `dropped` both 1.
- R9: `cmd_ready` falls in the cycle after a command is accepted and stays low until the done cycle has passed. Exactly one done pulse follows each accepted command.
- R10: `rq_rd` and `rq_wr` are never high together. `done` is high for a single cycle, and a write is always followed by a done with `dropped` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Dispatcher is idle and takes the offered command |
| cmd_port | input | 12 | Send-port offset the command was written to |
| cmd_data | input | 64 | Command word |
| rq_core | output | 10 | Target core of the current access |
| rq_addr | output | 16 | Register address on the target core |
| rq_rd | output | 1 | Read strobe; data is returned in the same cycle |
| rq_wr | output | 1 | Write strobe |
| rq_wdata | output | 32 | Write data |
| rq_rdata | input | 32 | Read data from the selected core |
| core_present | input | 1 | The core on `rq_core` exists |
| done | output | 1 | One-cycle pulse when a command completes |
| dropped | output | 1 | With `done`: the command made no access |

## Verification
Commands are issued on all three ports and spread over every core. The interrupt vectors include 0 and 31, and one interrupt command carries a set mask and a payload to show that both are ignored. The keep masks are all-clear, all-set, single-byte and two-byte. This separates the direct write from the read-merge-write path and checks each byte lane on its own. Mailbox commands fill the unused low bits with ones, which shows that only the three index bits choose the address. The absent cores include the highest core number, and two stray port offsets sit next to the real ones, so a drop caused by a missing core and a drop caused by a bad port are both checked at the bus.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;

    // widths fixed by the command word layout
    localparam int CMD_W    = 64;
    localparam int CORE_W   = 10;
    localparam int RA_W     = 16;
    localparam int DW       = 32;
    localparam int NB       = DW / 8;
    localparam int VEC_W    = 5;
    localparam int MBOX_W   = 3;

    // field positions inside the command word
    localparam int PAY_LSB  = 32;
    localparam int KEEP_LSB = 27;
    localparam int CORE_LSB = 16;
    localparam int MBOX_LSB = 2;

    typedef enum logic [1:0] {
        K_NONE,
        K_POST,
        K_MAIL,
        K_ANY
    } send_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_READ,
        S_WRITE,
        S_DONE
    } disp_state_e;

    typedef struct packed {
        send_kind_e          kind;
        logic [CORE_W-1:0]   core;
        logic [RA_W-1:0]     addr;
        logic [DW-1:0]       data;
        logic [NB-1:0]       keep;
    } send_op_t;

endpackage

// File: rtl/send_cmd_decode.sv
module send_cmd_decode
    import sdisp_pkg::*;
#(
    parameter int              PORT_W    = 12,
    parameter logic [PORT_W-1:0] POST_PORT = 12'h040,
    parameter logic [PORT_W-1:0] MAIL_PORT = 12'h048,
    parameter logic [PORT_W-1:0] ANY_PORT  = 12'h158,
    parameter logic [RA_W-1:0]   SET_REG   = 16'h0008,
    parameter logic [RA_W-1:0]   MBOX_BASE = 16'h0020
) (
    input  logic [PORT_W-1:0] cmd_port,
    input  logic [CMD_W-1:0]  cmd_data,
    output send_op_t          op
);

    logic [DW-1:0]     payload;
    logic [NB-1:0]     keep;
    logic [RA_W-1:0]   mbox_addr;
    logic [VEC_W-1:0]  vec;
    logic              unused_bits;

    assign payload     = cmd_data[PAY_LSB +: DW];
    assign keep        = cmd_data[KEEP_LSB +: NB];
    assign vec         = cmd_data[VEC_W-1:0];
    assign mbox_addr   = MBOX_BASE + RA_W'({cmd_data[MBOX_LSB +: MBOX_W], 2'b00});
    assign unused_bits = ^{cmd_data[31], cmd_data[26]};

    always_comb begin
        op      = '0;
        op.core = cmd_data[CORE_LSB +: CORE_W];
        if (cmd_port == POST_PORT) begin
            op.kind = K_POST;
            op.addr = SET_REG;
            op.data = DW'(1) << vec;
            op.keep = '0;
        end else if (cmd_port == MAIL_PORT) begin
            op.kind = K_MAIL;
            op.addr = mbox_addr;
            op.data = payload;
            op.keep = keep;
        end else if (cmd_port == ANY_PORT) begin
            op.kind = K_ANY;
            op.addr = cmd_data[RA_W-1:0];
            op.data = payload;
            op.keep = keep;
        end else begin
            op.kind = K_NONE;
        end
    end

endmodule

// File: rtl/send_byte_merge.sv
module send_byte_merge #(
    parameter int LANES = 4,
    localparam int W    = LANES * 8
) (
    input  logic [W-1:0]     old_word,
    input  logic [W-1:0]     new_word,
    input  logic [LANES-1:0] keep,
    output logic [W-1:0]     merged
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[b*8 +: 8] = keep[b] ? old_word[b*8 +: 8] : new_word[b*8 +: 8];
    end

endmodule

// File: rtl/send_ctrl.sv
module send_ctrl
    import sdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  send_op_t          op_in,
    input  logic              core_present,
    input  logic [DW-1:0]     merged,
    output logic [CORE_W-1:0] rq_core,
    output logic [RA_W-1:0]   rq_addr,
    output logic              rq_rd,
    output logic              rq_wr,
    output logic [DW-1:0]     rq_wdata,
    output logic [NB-1:0]     cur_keep,
    output logic              done,
    output logic              dropped
);

    typedef struct packed {
        disp_state_e st;
        send_op_t    op;
        logic        drop;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.op = op_in;
                    if (op_in.kind == K_NONE) begin
                        d.drop = 1'b1;
                        d.st   = S_DONE;
                    end else begin
                        d.drop = 1'b0;
                        d.st   = S_LOOK;
                    end
                end
            end
            S_LOOK: begin
                if (!core_present) begin
                    d.drop = 1'b1;
                    d.st   = S_DONE;
                end else if (|q.op.keep) begin
                    d.st   = S_READ;
                end else begin
                    d.st   = S_WRITE;
                end
            end
            S_READ: begin
                d.op.data = merged;
                d.st      = S_WRITE;
            end
            S_WRITE: d.st = S_DONE;
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.op   <= '0;
            q.drop <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == S_IDLE);
    assign rq_rd     = (q.st == S_READ);
    assign rq_wr     = (q.st == S_WRITE);
    assign done      = (q.st == S_DONE);
    assign dropped   = (q.st == S_DONE) && q.drop;
    assign rq_core   = q.op.core;
    assign rq_addr   = q.op.addr;
    assign rq_wdata  = q.op.data;
    assign cur_keep  = q.op.keep;

endmodule

// File: rtl/send_dispatch.sv
module send_dispatch
    import sdisp_pkg::*;
#(
    parameter int                PORT_W    = 12,
    parameter logic [PORT_W-1:0] POST_PORT = 12'h040,
    parameter logic [PORT_W-1:0] MAIL_PORT = 12'h048,
    parameter logic [PORT_W-1:0] ANY_GAP   = 12'h110,
    parameter logic [RA_W-1:0]   SET_REG   = 16'h0008,
    parameter logic [RA_W-1:0]   MBOX_BASE = 16'h0020,
    localparam logic [PORT_W-1:0] ANY_PORT = MAIL_PORT + ANY_GAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [PORT_W-1:0] cmd_port,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic [CORE_W-1:0] rq_core,
    output logic [RA_W-1:0]   rq_addr,
    output logic              rq_rd,
    output logic              rq_wr,
    output logic [DW-1:0]     rq_wdata,
    input  logic [DW-1:0]     rq_rdata,
    input  logic              core_present,
    output logic              done,
    output logic              dropped
);

    send_op_t      dec_op;
    logic [DW-1:0] merged;
    logic [NB-1:0] cur_keep;

    send_cmd_decode #(
        .PORT_W   (PORT_W),
        .POST_PORT(POST_PORT),
        .MAIL_PORT(MAIL_PORT),
        .ANY_PORT (ANY_PORT),
        .SET_REG  (SET_REG),
        .MBOX_BASE(MBOX_BASE)
    ) u_dec (
        .cmd_port(cmd_port),
        .cmd_data(cmd_data),
        .op      (dec_op)
    );

    send_byte_merge #(.LANES(NB)) u_merge (
        .old_word(rq_rdata),
        .new_word(rq_wdata),
        .keep    (cur_keep),
        .merged  (merged)
    );

    send_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .op_in       (dec_op),
        .core_present(core_present),
        .merged      (merged),
        .rq_core     (rq_core),
        .rq_addr     (rq_addr),
        .rq_rd       (rq_rd),
        .rq_wr       (rq_wr),
        .rq_wdata    (rq_wdata),
        .cur_keep    (cur_keep),
        .done        (done),
        .dropped     (dropped)
    );

endmodule

// File: rtl/send_dispatch_chk.sv
module send_dispatch_chk
    import sdisp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [11:0]       cmd_port,
    input logic [CMD_W-1:0]  cmd_data,
    input logic [CORE_W-1:0] rq_core,
    input logic [RA_W-1:0]   rq_addr,
    input logic              rq_rd,
    input logic              rq_wr,
    input logic [DW-1:0]     rq_wdata,
    input logic [DW-1:0]     rq_rdata,
    input logic              core_present,
    input logic              done,
    input logic              dropped
);

    logic unused_in;
    assign unused_in = ^{cmd_port, cmd_data, rq_wdata, rq_rdata};

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_rd && rq_wr)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R9

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rq_rd |=> (rq_wr && $stable(rq_addr) && $stable(rq_core))); // R7

    AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rq_wr |=> (done && !dropped)); // R10

    AST_ACCESS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_rd || rq_wr) |-> core_present); // R2

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!rq_rd && !rq_wr && !done)); // R1

endmodule

bind send_dispatch send_dispatch_chk u_chk (.*);

// File: tb/sim_send_dispatch.sv
module sim_send_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [11:0] cmd_port = '0;
    logic [63:0] cmd_data = '0;
    logic [9:0]  rq_core;
    logic [15:0] rq_addr;
    logic        rq_rd, rq_wr;
    logic [31:0] rq_wdata, rq_rdata;
    logic        core_present;
    logic        done, dropped;

    always #2 clk = ~clk; // 250 MHz

    send_dispatch u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_port(cmd_port), .cmd_data(cmd_data),
        .rq_core(rq_core), .rq_addr(rq_addr),
        .rq_rd(rq_rd), .rq_wr(rq_wr),
        .rq_wdata(rq_wdata), .rq_rdata(rq_rdata),
        .core_present(core_present),
        .done(done), .dropped(dropped)
    );

    // ---------------- target register model: 4 cores, 64 words each
    logic [31:0] mem [4][64];
    int          n_rd, n_wr, n_done;
    logic [9:0]  last_core;
    logic [15:0] last_addr;
    logic [31:0] last_data;

    assign core_present = (rq_core < 10'd4);
    assign rq_rdata     = core_present ? mem[rq_core[1:0]][rq_addr[7:2]] : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 64; i++)
                    mem[c][i] <= (i == 0) ? 32'h0 : {8'(c * 16 + i), 8'hC3, 8'(i), 8'(8'h5A ^ i)};
            n_rd <= 0; n_wr <= 0; n_done <= 0;
        end else begin
            if (rq_rd) n_rd <= n_rd + 1;
            if (done)  n_done <= n_done + 1;
            if (rq_wr) begin
                n_wr      <= n_wr + 1;
                last_core <= rq_core;
                last_addr <= rq_addr;
                last_data <= rq_wdata;
                if (core_present) begin
                    if (rq_addr == 16'h0008)
                        mem[rq_core[1:0]][0] <= mem[rq_core[1:0]][0] | rq_wdata;
                    else
                        mem[rq_core[1:0]][rq_addr[7:2]] <= rq_wdata;
                end
            end
        end
    end

    // ---------------- check bookkeeping
    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input logic [31:0] old, input logic [31:0] pay, input logic [3:0] keep);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = keep[b] ? old[b*8 +: 8] : pay[b*8 +: 8];
        return r;
    endfunction

    // ---------------- stimulus / expected table
    typedef struct packed {
        logic [11:0] port;
        logic [63:0] cmd;
        logic [15:0] eaddr;
        logic [1:0]  erd;
        logic [1:0]  ewr;
        logic        edrop;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R3 post vector 5 to core 1
        '{12'h040, {32'h0, 1'b0, 4'h0, 1'b0, 10'd1, 16'h0005}, 16'h0008, 2'd0, 2'd1, 1'b0},
        // R3 post vector 31 to core 3
        '{12'h040, {32'h0, 1'b0, 4'h0, 1'b0, 10'd3, 16'h001F}, 16'h0008, 2'd0, 2'd1, 1'b0},
        // R3 post vector 0, mask and payload ignored
        '{12'h040, {32'hFFFF_FFFF, 1'b0, 4'hF, 1'b0, 10'd2, 16'hFFE0}, 16'h0008, 2'd0, 2'd1, 1'b0},
        // R3 second vector to core 1 accumulates
        '{12'h040, {32'h0, 1'b0, 4'h0, 1'b0, 10'd1, 16'h000C}, 16'h0008, 2'd0, 2'd1, 1'b0},
        // R4 R6 mailbox 0, no mask
        '{12'h048, {32'h1122_3344, 1'b0, 4'h0, 1'b0, 10'd0, 16'h0000}, 16'h0020, 2'd0, 2'd1, 1'b0},
        // R7 mailbox 7, keep bytes 0 and 2
        '{12'h048, {32'hAABB_CCDD, 1'b0, 4'b0101, 1'b0, 10'd1, 16'h001C}, 16'h003C, 2'd1, 2'd1, 1'b0},
        // R7 mailbox 3, keep all
        '{12'h048, {32'h9999_9999, 1'b0, 4'hF, 1'b0, 10'd2, 16'h000C}, 16'h002C, 2'd1, 2'd1, 1'b0},
        // R7 mailbox 5, keep byte 3
        '{12'h048, {32'h0102_0304, 1'b0, 4'b1000, 1'b0, 10'd3, 16'h0014}, 16'h0034, 2'd1, 2'd1, 1'b0},
        // R4 junk low bits, index 6, keep byte 1
        '{12'h048, {32'h5566_7788, 1'b0, 4'b0010, 1'b0, 10'd1, 16'hFFF9}, 16'h0038, 2'd1, 2'd1, 1'b0},
        // R5 R6 arbitrary register 0x0010, no mask
        '{12'h158, {32'hCAFE_F00D, 1'b0, 4'h0, 1'b0, 10'd2, 16'h0010}, 16'h0010, 2'd0, 2'd1, 1'b0},
        // R5 R7 arbitrary register 0x00A4, keep bytes 0,1
        '{12'h158, {32'h0BAD_C0DE, 1'b0, 4'b0011, 1'b0, 10'd1, 16'h00A4}, 16'h00A4, 2'd1, 2'd1, 1'b0},
        // R2 mailbox to absent core 9
        '{12'h048, {32'h1234_5678, 1'b0, 4'h0, 1'b0, 10'd9, 16'h0004}, 16'h0000, 2'd0, 2'd0, 1'b1},
        // R2 arbitrary to absent core 1023 with mask
        '{12'h158, {32'h1234_5678, 1'b0, 4'hF, 1'b0, 10'd1023, 16'h0010}, 16'h0000, 2'd0, 2'd0, 1'b1},
        // R2 post to absent core 4
        '{12'h040, {32'h0, 1'b0, 4'h0, 1'b0, 10'd4, 16'h0003}, 16'h0000, 2'd0, 2'd0, 1'b1},
        // R8 stray port 0x050
        '{12'h050, {32'h7777_7777, 1'b0, 4'h0, 1'b0, 10'd1, 16'h0020}, 16'h0000, 2'd0, 2'd0, 1'b1},
        // R8 stray port 0x049
        '{12'h049, {32'h7777_7777, 1'b0, 4'h0, 1'b0, 10'd1, 16'h0020}, 16'h0000, 2'd0, 2'd0, 1'b1}
    };

    // ---------------- one command through the handshake
    task automatic run_cmd(input logic [11:0] port, input logic [63:0] cmd,
                           output bit seen, output logic got_drop, output bit busy_ok,
                           output int d_rd, output int d_wr, output int d_done);
        int r0, w0, k0;
        r0 = n_rd; w0 = n_wr; k0 = n_done;
        seen = 0; got_drop = 0; busy_ok = 1;
        @(negedge clk);
        cmd_port = port; cmd_data = cmd; cmd_valid = 1'b1;
        for (int i = 0; i < 50 && !cmd_ready; i++) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (cmd_ready) busy_ok = 0;
            if (done) begin
                seen = 1; got_drop = dropped;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        if (!cmd_ready) busy_ok = 0;
        d_rd = n_rd - r0; d_wr = n_wr - w0; d_done = n_done - k0;
    endtask

    // ---------------- watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- main sequence
    initial begin
        bit          seen, busy_ok;
        logic        gdrop;
        int          drd, dwr, ddone;
        logic [31:0] old, expv;
        int          c, idx;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !rq_rd && !rq_wr && !done, "R1 in reset",
            {cmd_ready, rq_rd, rq_wr, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !rq_rd && !rq_wr && !done, "R1 after reset",
            {cmd_ready, rq_rd, rq_wr, done}, 4'b1000);

        for (int v = 0; v < NV; v++) begin
            c   = int'(VECS[v].cmd[17:16]);
            idx = (VECS[v].port == 12'h040) ? 0 : int'(VECS[v].eaddr[7:2]);
            old = mem[c][idx];
            if (VECS[v].port == 12'h040)
                expv = old | (32'h1 << VECS[v].cmd[4:0]);
            else
                expv = mix(old, VECS[v].cmd[63:32], VECS[v].cmd[30:27]);

            run_cmd(VECS[v].port, VECS[v].cmd, seen, gdrop, busy_ok, drd, dwr, ddone);

            chk(seen && ddone == 1, $sformatf("R9 vec%0d one done", v), ddone, 1);
            chk(busy_ok, $sformatf("R9 vec%0d ready low while busy", v), busy_ok, 1);
            chk(gdrop == VECS[v].edrop, $sformatf("R2/R8 vec%0d drop flag", v), gdrop, VECS[v].edrop);
            chk(drd == int'(VECS[v].erd) && dwr == int'(VECS[v].ewr),
                $sformatf("R6/R7 vec%0d read,write counts", v), {drd[7:0], dwr[7:0]},
                {6'd0, VECS[v].erd, 6'd0, VECS[v].ewr});
            if (!VECS[v].edrop) begin
                chk(last_core == VECS[v].cmd[25:16] && last_addr == VECS[v].eaddr,
                    $sformatf("R4/R5 vec%0d core,addr", v), {last_core, last_addr},
                    {VECS[v].cmd[25:16], VECS[v].eaddr});
                chk(mem[c][idx] == expv, $sformatf("R3/R7 vec%0d stored value", v), mem[c][idx], expv);
                if (VECS[v].port == 12'h040)
                    chk(last_data == (32'h1 << VECS[v].cmd[4:0]), $sformatf("R3 vec%0d one-hot data", v),
                        last_data, 32'h1 << VECS[v].cmd[4:0]);
            end
        end

        // R9: reset in the middle of a command returns to idle
        @(negedge clk);
        cmd_port = 12'h048; cmd_data = {32'h1, 1'b0, 4'hF, 1'b0, 10'd0, 16'h0};
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R9 busy after accept", cmd_ready, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !rq_rd && !rq_wr && !done, "R1 reset mid-command",
            {cmd_ready, rq_rd, rq_wr, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !done, "R1 idle after reset release", {cmd_ready, done}, 2'b10);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule